// File: doc/BRIEF.md
# Infrared Transceiver Configuration Pin Controller

This block sets the levels on three bidirectional configuration pads of an external infrared transceiver, and samples those three pads together with a fourth, input-only pad. The levels either follow a software-written field directly or come from a per-mode pattern table. In the second case the pattern is applied automatically each time a new operating mode is entered. Software writes the level field, the control bits and the table through a simple write port. The mode logic announces a mode change with a one-cycle strobe and the mode number.

The direction of the pads is split into two groups. Pad 0 has its own output-enable bit, and pads 2 and 1 share a second one. While pad 0 is an input, it can be taken as a second infrared receive-data line, and only pads 2 and 1 then configure the transceiver. All four pad inputs pass through a two-flop synchronizer, which forms a 4-bit identification value for reading a plug-in adapter's ID. Pipelined mode switching can only be requested while automatic configuration is on.

Top module: `irx_pin_ctrl`

## Requirements
- R1: While reset is asserted and right after it, pin_oe is 000, pin_o is 000, id_val is 0, rx2_o is 0 and pipe_en is 0.
- R2: With automatic configuration off (control register, address 1, bit 0 = 0), pin_o equals bits [2:0] of the level register (address 0), one cycle after the write.
- R3: With automatic configuration on, a mode_stb with mode m loads table entry m (address 2+m, bits [2:0]) onto pin_o in the cycle after the strobe.
- R4: With automatic configuration on, pin_o holds between strobes. Table writes and level-register writes do not change it until the next strobe. A strobe while automatic configuration is off loads nothing.
- R5: pin_oe[0] equals control bit 2, and pin_oe[2] and pin_oe[1] both equal control bit 3; a 1 means drive.
- R6: When control bit 4 is 1 and control bit 2 is 0, rx2_o carries the synchronized pad-0 input (equal to id_val[0]). Otherwise rx2_o is 0.
- R7: id_val[3:0] equals the pin_i value that was present two rising clock edges earlier. Bit 3 is the input-only pad.
- R8: pipe_en becomes control bit 1 only when the same write also sets control bit 0. A pipelining request written with bit 0 = 0 is ignored and leaves pipe_en at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 level, 1 control, 2..5 mode table) |
| wr_data | input | 8 | Register write data |
| mode_sel | input | 2 | Mode being entered (0..3) |
| mode_stb | input | 1 | One-cycle mode-change strobe |
| pin_i | input | 4 | Pad inputs; bit 3 is the input-only pad |
| pin_o | output | 3 | Output levels for the bidirectional pads |
| pin_oe | output | 3 | Output enables for the bidirectional pads |
| id_val | output | 4 | Synchronized adapter identification value |
| rx2_o | output | 1 | Alternate receive data taken from pad 0 |
| pipe_en | output | 1 | Pipelined mode switching enabled |

## Verification
The reference model is first driven with directed sequences. A distinct pattern is programmed into each table entry so that a wrong index shows up as a wrong level. A strobe is sent while automatic configuration is off, and again with the table rewritten after a strobe; these two cases separate strobe-driven loading from a level that follows the table directly. Walking pad patterns with changes one cycle apart expose a synchronizer that is too short or too long. The alternate receive path is tried with pad 0 set first as an output and then as an input. A long phase of random writes, strobes and pad values then mixes all modes, including a write and a strobe in the same cycle.

// File: rtl/irx_pin_pkg.sv
package irx_pin_pkg;
  localparam int CTRL_AUTO  = 0;
  localparam int CTRL_PIPE  = 1;
  localparam int CTRL_DRV0  = 2;
  localparam int CTRL_DRV21 = 3;
  localparam int CTRL_ALT   = 4;

  localparam int ADDR_LEVEL    = 0;
  localparam int ADDR_CTRL     = 1;
  localparam int ADDR_TBL_BASE = 2;

  typedef struct packed {
    logic alt_rx;
    logic drv_hi;
    logic drv_lo;
    logic pipe;
    logic auto_cfg;
  } ctrl_t;

  // pipelining is accepted only together with automatic configuration
  function automatic ctrl_t decode_ctrl(input logic [4:0] d);
    ctrl_t c;
    c.auto_cfg = d[CTRL_AUTO];
    c.pipe     = d[CTRL_PIPE] & d[CTRL_AUTO];
    c.drv_lo   = d[CTRL_DRV0];
    c.drv_hi   = d[CTRL_DRV21];
    c.alt_rx   = d[CTRL_ALT];
    return c;
  endfunction

  function automatic logic [2:0] oe_map(input ctrl_t c);
    return {c.drv_hi, c.drv_hi, c.drv_lo};
  endfunction

  function automatic logic alt_active(input ctrl_t c);
    return c.alt_rx & ~c.drv_lo;
  endfunction
endpackage

// File: rtl/irx_cfg_regs.sv
module irx_cfg_regs
  import irx_pin_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 8,
  parameter int CFG_PINS  = 3,
  parameter int NUM_MODES = 4,
  parameter int MODE_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [MODE_W-1:0]   mode_sel,
  output logic [CFG_PINS-1:0] man_lvl,
  output ctrl_t               ctrl,
  output logic [CFG_PINS-1:0] tbl_sel
);
  logic [NUM_MODES-1:0][CFG_PINS-1:0] tbl_q;
  logic [CFG_PINS-1:0] man_q;
  ctrl_t ctrl_q;

  wire hit_level = wr_en && (wr_addr == ADDR_W'(ADDR_LEVEL));
  wire hit_ctrl  = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      man_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (hit_level) man_q <= wr_data[CFG_PINS-1:0];
      if (hit_ctrl)  ctrl_q <= decode_ctrl(wr_data[4:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl_q <= '0;
    end else begin
      for (int m = 0; m < NUM_MODES; m++) begin
        if (wr_en && (wr_addr == ADDR_W'(ADDR_TBL_BASE + m)))
          tbl_q[m] <= wr_data[CFG_PINS-1:0];
      end
    end
  end

  always_comb begin
    tbl_sel = '0;
    if (int'(mode_sel) < NUM_MODES) tbl_sel = tbl_q[mode_sel];
  end

  assign man_lvl = man_q;
  assign ctrl    = ctrl_q;

  // R2: a level write is visible on the next cycle
  a_r2_level_write: assert property (@(posedge clk) disable iff (!rst_n)
    hit_level |=> man_lvl == $past(wr_data[CFG_PINS-1:0]));
  // R8: a pipelining request without automatic configuration is dropped
  a_r8_pipe_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_ctrl && !wr_data[CTRL_AUTO]) |=> !ctrl.pipe);
endmodule

// File: rtl/irx_pin_sync.sv
module irx_pin_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d_i;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
      // R7: every stage takes the previous one's value
      a_r7_chain: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> stage_q[s] == $past(stage_q[s-1]));
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irx_pin_drive.sv
module irx_pin_drive
  import irx_pin_pkg::*;
#(
  parameter int CFG_PINS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_stb,
  input  ctrl_t               ctrl,
  input  logic [CFG_PINS-1:0] man_lvl,
  input  logic [CFG_PINS-1:0] tbl_sel,
  output logic [CFG_PINS-1:0] pin_o,
  output logic [CFG_PINS-1:0] pin_oe
);
  logic [CFG_PINS-1:0] auto_lvl_q;
  wire load_ev = mode_stb & ctrl.auto_cfg;

  always_ff @(posedge clk) begin
    if (!rst_n)       auto_lvl_q <= '0;
    else if (load_ev) auto_lvl_q <= tbl_sel;
  end

  assign pin_o  = ctrl.auto_cfg ? auto_lvl_q : man_lvl;
  assign pin_oe = CFG_PINS'(oe_map(ctrl));

  // R3: a strobe in automatic mode captures the selected table entry
  a_r3_auto_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> auto_lvl_q == $past(tbl_sel));
  // R4: without a qualifying strobe the automatic pattern holds
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_ev |=> $stable(auto_lvl_q));
endmodule

// File: rtl/irx_pin_ctrl.sv
module irx_pin_ctrl
  import irx_pin_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int CFG_PINS    = 3,
  parameter int NUM_MODES   = 4,
  parameter int SYNC_STAGES = 2,
  localparam int MODE_W     = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1,
  localparam int ID_W       = CFG_PINS + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [MODE_W-1:0]   mode_sel,
  input  logic                mode_stb,
  input  logic [ID_W-1:0]     pin_i,
  output logic [CFG_PINS-1:0] pin_o,
  output logic [CFG_PINS-1:0] pin_oe,
  output logic [ID_W-1:0]     id_val,
  output logic                rx2_o,
  output logic                pipe_en
);
  ctrl_t ctrl;
  logic [CFG_PINS-1:0] man_lvl, tbl_sel;
  logic [ID_W-1:0] id_sync;

  irx_cfg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_PINS(CFG_PINS),
    .NUM_MODES(NUM_MODES), .MODE_W(MODE_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mode_sel(mode_sel), .man_lvl(man_lvl),
    .ctrl(ctrl), .tbl_sel(tbl_sel)
  );

  irx_pin_drive #(.CFG_PINS(CFG_PINS)) u_drive (
    .clk(clk), .rst_n(rst_n), .mode_stb(mode_stb), .ctrl(ctrl),
    .man_lvl(man_lvl), .tbl_sel(tbl_sel), .pin_o(pin_o), .pin_oe(pin_oe)
  );

  irx_pin_sync #(.WIDTH(ID_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(id_sync)
  );

  wire alt_on = alt_active(ctrl);

  assign id_val  = id_sync;
  assign rx2_o   = alt_on & id_sync[0];
  assign pipe_en = ctrl.pipe;

  // R6: pad 0 is never driven while it serves as the alternate receive line
  a_r6_alt_input: assert property (@(posedge clk) disable iff (!rst_n)
    alt_on |-> !pin_oe[0]);
  // R8: pipelining never stands without automatic configuration
  a_r8_pipe_auto: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_en |-> ctrl.auto_cfg);
endmodule

// File: tb/irx_pin_ctrl_test.sv
`timescale 1ns/1ps
module irx_pin_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] mode_sel = '0;
  logic mode_stb = 1'b0;
  logic [3:0] pin_i = '0;
  logic [2:0] pin_o, pin_oe;
  logic [3:0] id_val;
  logic rx2_o, pipe_en;

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;

  always #2.5 clk = ~clk;

  irx_pin_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mode_sel(mode_sel), .mode_stb(mode_stb),
    .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe), .id_val(id_val),
    .rx2_o(rx2_o), .pipe_en(pipe_en)
  );

  // behavioural reference
  logic [2:0] m_man, m_alvl;
  logic [2:0] m_tbl [4];
  bit m_auto, m_pipe, m_drv0, m_drv21, m_alt;
  logic [3:0] hist [$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_man = 0; m_alvl = 0; m_auto = 0; m_pipe = 0;
      m_drv0 = 0; m_drv21 = 0; m_alt = 0;
      for (int k = 0; k < 4; k++) m_tbl[k] = 0;
      hist.delete();
    end else begin
      if (mode_stb && m_auto) m_alvl = m_tbl[mode_sel];
      if (wr_en) begin
        if (wr_addr == 0) m_man = wr_data[2:0];
        else if (wr_addr == 1) begin
          m_auto = wr_data[0]; m_pipe = wr_data[1] && wr_data[0];
          m_drv0 = wr_data[2]; m_drv21 = wr_data[3]; m_alt = wr_data[4];
        end else if (wr_addr >= 2 && wr_addr <= 5) m_tbl[wr_addr-2] = wr_data[2:0];
      end
      hist.push_back(pin_i);
      if (hist.size() > 2) void'(hist.pop_front());
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      logic [3:0] e_id;
      e_id = (hist.size() == 2) ? hist[0] : 4'h0;
      if (m_auto) chk("R3/R4 pin_o auto", 8'(pin_o), 8'(m_alvl));
      else        chk("R2 pin_o manual", 8'(pin_o), 8'(m_man));
      chk("R5 pin_oe", 8'(pin_oe), 8'({m_drv21, m_drv21, m_drv0}));
      chk("R7 id_val", 8'(id_val), 8'(e_id));
      chk("R6 rx2_o", 8'(rx2_o), 8'((m_alt && !m_drv0) ? e_id[0] : 1'b0));
      chk("R8 pipe_en", 8'(pipe_en), 8'(m_pipe));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic stb(input logic [1:0] m);
    @(negedge clk); mode_stb = 1; mode_sel = m;
    @(negedge clk); mode_stb = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    finish_run();
  end

  initial begin
    pin_i = 4'hF;
    repeat (3) @(negedge clk);
    // R1: state while in reset
    chk("R1 pin_oe in reset", 8'(pin_oe), 8'h0);
    chk("R1 pin_o in reset", 8'(pin_o), 8'h0);
    chk("R1 id_val in reset", 8'(id_val), 8'h0);
    chk("R1 pipe_en in reset", 8'(pipe_en), 8'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 pin_oe after reset", 8'(pin_oe), 8'h0);
    chk("R1 rx2_o after reset", 8'(rx2_o), 8'h0);
    cmp_on = 1;

    // R2 manual levels, R5 directions
    wr(0, 8'h05); wr(0, 8'hFA);
    wr(1, 8'h04); wr(1, 8'h08); wr(1, 8'h0C);
    // R8 pipelining without auto is ignored
    wr(1, 8'h0E);
    // R7 walking pad patterns
    for (int k = 0; k < 4; k++) begin @(negedge clk); pin_i = 4'(1 << k); end
    pin_i = 4'hA; idle(1); pin_i = 4'h5; idle(3);
    // R6 alternate receive: pad 0 output then input
    wr(1, 8'h14);
    pin_i = 4'h1; idle(3); pin_i = 4'h0; idle(3);
    wr(1, 8'h18);
    pin_i = 4'h1; idle(3); pin_i = 4'h0; idle(1); pin_i = 4'h1; idle(3);
    // R3 automatic table with distinct entries
    wr(2, 8'h03); wr(3, 8'h05); wr(4, 8'h06); wr(5, 8'h01);
    wr(1, 8'h0B);
    stb(0); stb(1); stb(2); stb(3); stb(2);
    // R4 table and level writes do not move pin_o until next strobe
    wr(4, 8'h07); wr(0, 8'h02); idle(2);
    stb(2); idle(1);
    // R4 strobe with auto off loads nothing
    wr(1, 8'h0C); stb(0); wr(1, 8'h0D); idle(2);
    // same-cycle table write and strobe uses old entry
    @(negedge clk); wr_en = 1; wr_addr = 2; wr_data = 8'h04; mode_stb = 1; mode_sel = 0;
    @(negedge clk); wr_en = 0; mode_stb = 0;
    idle(2);

    // random mix
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      wr_en    = ($urandom_range(0, 2) == 0);
      wr_addr  = 3'($urandom_range(0, 5));
      wr_data  = 8'($urandom);
      mode_stb = ($urandom_range(0, 3) == 0);
      mode_sel = 2'($urandom);
      pin_i    = 4'($urandom);
    end
    @(negedge clk); wr_en = 0; mode_stb = 0;
    idle(4);
    finish_run();
  end
endmodule